// File: doc/BRIEF.md
# SRAM DLL Bring-Up Sequencer

This controller-side state machine takes an external DDR SRAM that has an internal delay-locked loop from power-on to normal operation. It switches on the three supply rails one after another: core first, then I/O, then reference. Each step waits for that rail's power-good input and then for a settle interval. While the rails come up, the DLL stays disabled and the memory clock is gated off.

Once all rails have settled, the memory clock is enabled. After the clock source reports that it is stable, the block takes one of two paths:

- **Pin-controlled path:** it releases the DLL enable and counts the lock interval.
- **Pin-tied path:** the board holds the DLL permanently enabled. The block gates the memory clock off for a minimum stop time so that the DLL resets, then restarts the clock and counts the lock interval.

At the end of the lock interval, `ready` rises. A relock request, for example after a change of memory clock frequency, drops `ready` and repeats the DLL reset and the full lock count. If the frequency is flagged as too low for the DLL, the block raises `fault` and never asserts `ready`.

All inputs are assumed synchronous to `clk`. The memory clock is taken to run at the same rate as `clk`, so lock cycles are counted in `clk` cycles. A parameter lets the reference rail be enabled in the same step as the I/O rail.

Top module: `sram_dll_bringup`

## Requirements
- R1: While `rst` is high, all outputs are low: `rail_on` = 000, `dll_enable` = 0, `mclk_en` = 0, `ready` = 0, `fault` = 0.
- R2: Rail bits are `rail_on[0]` core, `rail_on[1]` I/O and `rail_on[2]` reference. Rails switch on cumulatively in that order. `rail_on[0]` rises on the first edge after reset. Each later step's enable rises `SETTLE_CYC`+2 cycles after the previous step's enable, given that the previous rail's power-good arrives before the next edge.
- R3: `dll_enable` stays low until all rails have settled and `clk_settled` is sampled high. In pin-controlled mode it rises on the edge after `clk_settled` is first seen.
- R4: `mclk_en` stays low during rail power-up and rises `SETTLE_CYC`+2 cycles after the last rail enable.
- R5: In pin-controlled mode (`dll_pin_tied` = 0), `ready` rises exactly `LOCK_CYC` (default 1024) cycles after `dll_enable` rises.
- R6: In pin-tied mode (`dll_pin_tied` = 1), `mclk_en` falls on the edge after `clk_settled` is seen. It stays low for exactly ceil(`STOP_NS`×1000/`CLK_PERIOD_PS`) cycles (default 6), then rises together with `dll_enable`. `ready` follows `LOCK_CYC` cycles later.
- R7: A `relock_req` pulse in the ready state clears `ready` and `dll_enable` on the next edge. `ready` returns only after a complete new lock interval. In pin-tied mode the clock-stop interval is repeated first.
- R8: If `freq_in_range` is low once the clocks run, `fault` rises and `ready` stays low, and the two are never high together. `fault` clears only on a `relock_req` while `freq_in_range` is high.
- R9: In pin-controlled mode, a drop of `clk_settled` during the lock count clears `dll_enable` on the next edge. The full lock count restarts after `clk_settled` returns.
- R10: In pin-tied mode, a drop of `clk_settled` during the lock count restarts the count without stopping the clock again. `ready` rises exactly `LOCK_CYC` cycles after `clk_settled` returns.
- R11: A `relock_req` sampled on the very edge at which the lock count would finish takes priority: `ready` does not rise.
- R12: Whenever `ready` is high, `dll_enable`, `mclk_en` and all three rail enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_good | input | 3 | Per-rail power-good (bit 0 core, 1 I/O, 2 reference) |
| clk_settled | input | 1 | Memory clock source reports a stable frequency |
| dll_pin_tied | input | 1 | 1: DLL control pin tied enabled on the board, use the clock-stop path |
| relock_req | input | 1 | Frequency changed; reset and relock the DLL |
| freq_in_range | input | 1 | Configured memory clock is fast enough for the DLL |
| rail_on | output | 3 | Rail enables (bit 0 core, 1 I/O, 2 reference) |
| dll_enable | output | 1 | DLL enable to the memory, low keeps the DLL off |
| mclk_en | output | 1 | Memory clock gate enable |
| ready | output | 1 | DLL locked, memory usable |
| fault | output | 1 | Clock frequency too low for the DLL |

## Verification
The two functions that can meet in a single cycle are lock completion and a relock request. The bench times a one-cycle `relock_req` pulse so that it is sampled on exactly the edge where the lock count would finish. The scoreboard then expects `dll_enable` to fall on that edge and `ready` to appear only one full lock interval after the re-release. The same scoreboard also meets a clock-stability drop in the middle of a lock count in both modes, and it rejects any output change that was not predicted.

// File: rtl/sram_pwr_pkg.sv
`timescale 1ns/1ps
package sram_pwr_pkg;

  localparam int N_RAILS = 3;

  typedef enum logic [2:0] {
    ST_RAILS,
    ST_WAIT_CLK,
    ST_STOP,
    ST_LOCK,
    ST_READY,
    ST_FAULT
  } bring_st_t;

  typedef enum logic [1:0] {
    PH_ENABLE,
    PH_WAIT_PG,
    PH_SETTLE,
    PH_DONE
  } rail_ph_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/pwr_timer.sv
`timescale 1ns/1ps
module pwr_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic last
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign last = (cnt == LAST);

  // R5: the interval counter never runs past its terminal value
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/pwr_rail_seq.sv
`timescale 1ns/1ps
module pwr_rail_seq
  import sram_pwr_pkg::*;
#(
  parameter int SETTLE_CYC  = 16,
  parameter bit REF_WITH_IO = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RAILS-1:0] rail_good,
  output logic [N_RAILS-1:0] rail_on,
  output logic               rails_up
);

  localparam int NSTEPS = REF_WITH_IO ? 2 : 3;
  localparam int SW     = $clog2(NSTEPS);
  localparam logic [SW-1:0] LAST_STEP = SW'(NSTEPS - 1);

  logic [SW-1:0]      step;
  rail_ph_t           ph;
  logic               settle_last;
  logic [N_RAILS-1:0] step_mask;

  generate
    if (REF_WITH_IO) begin : g_merged
      always_comb begin
        step_mask = (step == '0) ? 3'b001 : 3'b110;
      end
    end else begin : g_split
      always_comb begin
        step_mask = 3'b001 << step;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= '0;
      ph       <= PH_ENABLE;
      rail_on  <= '0;
      rails_up <= 1'b0;
    end else begin
      unique case (ph)
        PH_ENABLE: begin
          rail_on <= rail_on | step_mask;
          ph      <= PH_WAIT_PG;
        end
        PH_WAIT_PG: begin
          if ((rail_good & rail_on) == rail_on) ph <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (settle_last) begin
            if (step == LAST_STEP) begin
              ph       <= PH_DONE;
              rails_up <= 1'b1;
            end else begin
              step <= step + 1'b1;
              ph   <= PH_ENABLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  pwr_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .clr  (ph != PH_SETTLE),
    .en   (ph == PH_SETTLE),
    .last (settle_last)
  );

  // R2: I/O rail never on without core rail
  a_r2_io_after_core: assert property (@(posedge clk) disable iff (rst)
    rail_on[1] |-> rail_on[0]);

  // R2: reference rail never on without I/O rail
  a_r2_ref_after_io: assert property (@(posedge clk) disable iff (rst)
    rail_on[2] |-> rail_on[1]);

  // R4: completion is only reported with every rail switched on
  a_r4_up_all_rails: assert property (@(posedge clk) disable iff (rst)
    rails_up |-> (rail_on == 3'b111));

endmodule

// File: rtl/sram_dll_bringup.sv
`timescale 1ns/1ps
module sram_dll_bringup
  import sram_pwr_pkg::*;
#(
  parameter int SETTLE_CYC    = 16,
  parameter int LOCK_CYC      = 1024,
  parameter int STOP_NS       = 30,
  parameter int CLK_PERIOD_PS = 5000,
  parameter bit REF_WITH_IO   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rail_good,
  input  logic       clk_settled,
  input  logic       dll_pin_tied,
  input  logic       relock_req,
  input  logic       freq_in_range,
  output logic [2:0] rail_on,
  output logic       dll_enable,
  output logic       mclk_en,
  output logic       ready,
  output logic       fault
);

  localparam int STOP_CYC = ceil_div(STOP_NS * 1000, CLK_PERIOD_PS);

  bring_st_t st, nxt;
  logic      rails_up;
  logic      stop_last;
  logic      lock_last;

  pwr_rail_seq #(
    .SETTLE_CYC  (SETTLE_CYC),
    .REF_WITH_IO (REF_WITH_IO)
  ) u_rails (
    .clk       (clk),
    .rst       (rst),
    .rail_good (rail_good),
    .rail_on   (rail_on),
    .rails_up  (rails_up)
  );

  pwr_timer #(.LIMIT(STOP_CYC)) u_stop (
    .clk  (clk),
    .rst  (rst),
    .clr  (st != ST_STOP),
    .en   (1'b1),
    .last (stop_last)
  );

  pwr_timer #(.LIMIT(LOCK_CYC)) u_lock (
    .clk  (clk),
    .rst  (rst),
    .clr  ((st != ST_LOCK) || !clk_settled),
    .en   (1'b1),
    .last (lock_last)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_RAILS: begin
        if (rails_up) nxt = ST_WAIT_CLK;
      end
      ST_WAIT_CLK: begin
        if (!freq_in_range)   nxt = ST_FAULT;
        else if (clk_settled) nxt = dll_pin_tied ? ST_STOP : ST_LOCK;
      end
      ST_STOP: begin
        if (!freq_in_range)  nxt = ST_FAULT;
        else if (relock_req) nxt = ST_WAIT_CLK;
        else if (stop_last)  nxt = ST_LOCK;
      end
      ST_LOCK: begin
        if (!freq_in_range)                                 nxt = ST_FAULT;
        else if (relock_req || (!dll_pin_tied && !clk_settled)) nxt = ST_WAIT_CLK;
        else if (clk_settled && lock_last)                  nxt = ST_READY;
      end
      ST_READY: begin
        if (!freq_in_range)  nxt = ST_FAULT;
        else if (relock_req) nxt = ST_WAIT_CLK;
      end
      ST_FAULT: begin
        if (relock_req && freq_in_range) nxt = ST_WAIT_CLK;
      end
      default: nxt = ST_RAILS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_RAILS;
      dll_enable <= 1'b0;
      mclk_en    <= 1'b0;
      ready      <= 1'b0;
      fault      <= 1'b0;
    end else begin
      st         <= nxt;
      dll_enable <= (nxt == ST_LOCK) || (nxt == ST_READY);
      mclk_en    <= (nxt == ST_WAIT_CLK) || (nxt == ST_LOCK) ||
                    (nxt == ST_READY) || (nxt == ST_FAULT);
      ready      <= (nxt == ST_READY);
      fault      <= (nxt == ST_FAULT);
    end
  end

  // R3: DLL stays disabled until the rail sequencer reports completion
  a_r3_dll_off_in_rails: assert property (@(posedge clk) disable iff (rst)
    !rails_up |-> !dll_enable);

  // R4: memory clock gated during rail power-up
  a_r4_clk_off_in_rails: assert property (@(posedge clk) disable iff (rst)
    !rails_up |-> !mclk_en);

  // R5: ready only follows an enabled DLL
  a_r5_ready_after_dll: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(dll_enable));

  // R6: the memory clock is only ever stopped on the pin-tied path
  a_r6_stop_only_tied: assert property (@(posedge clk) disable iff (rst)
    $fell(mclk_en) |-> dll_pin_tied);

  // R7: a relock request always leaves ready low in the next cycle
  a_r7_relock_drops_ready: assert property (@(posedge clk) disable iff (rst)
    relock_req |=> !ready);

  // R8: low frequency blocks ready in the next cycle
  a_r8_low_freq_blocks: assert property (@(posedge clk) disable iff (rst)
    !freq_in_range |=> !ready);

  // R8: fault and ready exclusive
  a_r8_fault_excl: assert property (@(posedge clk) disable iff (rst)
    !(ready && fault));

  // R12: ready implies the whole power and clock chain is on
  a_r12_ready_chain: assert property (@(posedge clk) disable iff (rst)
    ready |-> (dll_enable && mclk_en && (rail_on == 3'b111)));

endmodule

// File: tb/sram_dll_bringup_test.sv
`timescale 1ns/1ps
module sram_dll_bringup_test;

  localparam int S    = 16;
  localparam int L    = 1024;
  localparam int STOP = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rail_good = 3'b000;
  logic       clk_settled = 1'b0;
  logic       dll_pin_tied = 1'b0;
  logic       relock_req = 1'b0;
  logic       freq_in_range = 1'b1;
  logic [2:0] rail_on;
  logic       dll_enable, mclk_en, ready, fault;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  logic [6:0] qv[$];
  int         qgap[$];
  int         qat[$];
  string      qtag[$];
  logic [6:0] prev_o;
  int         last_chg = 0;

  always #2.5 clk = ~clk;

  sram_dll_bringup uut (
    .clk           (clk),
    .rst           (rst),
    .rail_good     (rail_good),
    .clk_settled   (clk_settled),
    .dll_pin_tied  (dll_pin_tied),
    .relock_req    (relock_req),
    .freq_in_range (freq_in_range),
    .rail_on       (rail_on),
    .dll_enable    (dll_enable),
    .mclk_en       (mclk_en),
    .ready         (ready),
    .fault         (fault)
  );

  wire [6:0] outs = {fault, ready, mclk_en, dll_enable, rail_on};

  always @(posedge clk) cyc <= cyc + 1;

  // rail model: power-good follows enable half a cycle later
  always @(negedge clk) rail_good <= rail_on;

  task automatic check(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver side: schedule one expected output change
  task automatic expect_chg(input logic [6:0] v, input int gap, input int at, input string tag);
    qv.push_back(v);
    qgap.push_back(gap);
    qat.push_back(at);
    qtag.push_back(tag);
  endtask

  task automatic pulse_relock();
    relock_req = 1'b1;
    @(negedge clk);
    relock_req = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor side: pop and compare on every output change
  always @(negedge clk) begin : mon
    logic [6:0] v;
    int g, a;
    string t;
    if (mon_on && (outs !== prev_o)) begin
      checks++;
      if (qv.size() == 0) begin
        errors++;
        $display("FAIL unscheduled change (R1..R12 sequence): actual %b expected %b at cycle %0d",
                 outs, prev_o, cyc);
      end else begin
        v = qv.pop_front();
        g = qgap.pop_front();
        a = qat.pop_front();
        t = qtag.pop_front();
        if ((outs !== v) || (g != 0 && (cyc - last_chg) != g) || (a != 0 && cyc != a)) begin
          errors++;
          $display("FAIL %s: actual %b at cycle %0d gap %0d, expected %b at cycle %0d gap %0d",
                   t, outs, cyc, cyc - last_chg, v, a, g);
        end
      end
      prev_o   = outs;
      last_chg = cyc;
    end
  end

  initial begin : drive
    int c, c0, d, e, f, g, h, lk, k, tmem;
    repeat (3) @(negedge clk);
    check(outs === 7'b0000000, "R1 reset outputs", outs, 7'b0000000);
    check(dll_enable === 1'b0, "R1 dll disabled in reset", {6'b0, dll_enable}, 7'b0);
    prev_o = outs;
    mon_on = 1'b1;

    // pin-controlled bring-up
    c = cyc;
    expect_chg(7'b0000001, 0, c + 1, "R2 core rail first");
    expect_chg(7'b0000011, S + 2, 0, "R2 io rail spacing");
    expect_chg(7'b0000111, S + 2, 0, "R2 ref rail spacing");
    expect_chg(7'b0010111, S + 2, 0, "R4 memory clock on");
    rst = 1'b0;
    tmem = c + 1 + 3 * (S + 2);
    wait_until(tmem + 5);
    check(dll_enable === 1'b0, "R3 dll held until clock stable", {6'b0, dll_enable}, 7'b0);
    c = cyc;
    expect_chg(7'b0011111, 0, c + 1, "R3 dll release");
    expect_chg(7'b0111111, L, 0, "R5 lock interval");
    clk_settled = 1'b1;
    wait_until(c + 1 + L + 3);

    // relock
    c = cyc;
    expect_chg(7'b0010111, 0, c + 1, "R7 relock drops ready");
    expect_chg(7'b0011111, 1, 0, "R7 dll re-release");
    expect_chg(7'b0111111, L, 0, "R7 full relock interval");
    pulse_relock();
    wait_until(c + 2 + L + 3);

    // relock on the completion edge
    c = cyc;
    c0 = c + 2;
    expect_chg(7'b0010111, 0, c + 1, "R11 first relock");
    expect_chg(7'b0011111, 0, c0, "R11 dll release");
    expect_chg(7'b0010111, 0, c0 + L, "R11 relock wins over completion");
    expect_chg(7'b0011111, 0, c0 + L + 1, "R11 dll re-release");
    expect_chg(7'b0111111, 0, c0 + 2 * L + 1, "R11 ready after fresh count");
    pulse_relock();
    wait_until(c0 + L - 1);
    pulse_relock();
    wait_until(c0 + 2 * L + 4);

    // clock-stable drop in pin-controlled lock
    c = cyc;
    expect_chg(7'b0010111, 0, c + 1, "R9 setup relock");
    expect_chg(7'b0011111, 0, c + 2, "R9 setup release");
    pulse_relock();
    d = c + 102;
    wait_until(d);
    expect_chg(7'b0010111, 0, d + 1, "R9 dll off on clock loss");
    expect_chg(7'b0011111, 0, d + 6, "R9 dll back after clock return");
    expect_chg(7'b0111111, 0, d + 6 + L, "R9 full count after clock return");
    clk_settled = 1'b0;
    repeat (5) @(negedge clk);
    clk_settled = 1'b1;
    wait_until(d + 6 + L + 3);

    // low frequency fault
    e = cyc;
    expect_chg(7'b1010111, 0, e + 1, "R8 fault raised");
    freq_in_range = 1'b0;
    repeat (5) @(negedge clk);
    pulse_relock();
    repeat (5) @(negedge clk);
    check(fault === 1'b1 && ready === 1'b0, "R8 fault held, relock ignored while low",
          {5'b0, fault, ready}, 7'b0000010);
    freq_in_range = 1'b1;
    @(negedge clk);
    e = cyc;
    expect_chg(7'b0010111, 0, e + 1, "R8 fault cleared by relock");
    expect_chg(7'b0011111, 0, e + 2, "R8 dll release");
    expect_chg(7'b0111111, 0, e + 2 + L, "R8 ready after recovery");
    pulse_relock();
    wait_until(e + 2 + L + 3);

    // pin-tied bring-up
    f = cyc;
    expect_chg(7'b0000000, 0, f + 1, "R1 reset clears outputs");
    rst = 1'b1;
    dll_pin_tied = 1'b1;
    repeat (3) @(negedge clk);
    check(outs === 7'b0000000, "R1 reset outputs tied mode", outs, 7'b0000000);
    g = cyc;
    expect_chg(7'b0000001, 0, g + 1, "R2 core rail first");
    expect_chg(7'b0000011, S + 2, 0, "R2 io rail spacing");
    expect_chg(7'b0000111, S + 2, 0, "R2 ref rail spacing");
    expect_chg(7'b0010111, S + 2, 0, "R4 memory clock on");
    expect_chg(7'b0000111, 1, 0, "R6 clock stopped");
    expect_chg(7'b0011111, STOP, 0, "R6 stop interval length");
    expect_chg(7'b0111111, L, 0, "R6 lock interval");
    rst = 1'b0;
    wait_until(g + 1 + 3 * (S + 2) + 1 + STOP + L + 3);

    // tied relock with clock-stable drop mid-count
    h = cyc;
    lk = h + 2 + STOP;
    k = lk + 50;
    expect_chg(7'b0010111, 0, h + 1, "R7 tied relock drops ready");
    expect_chg(7'b0000111, 0, h + 2, "R7 tied clock stop repeated");
    expect_chg(7'b0011111, 0, lk, "R7 tied clock restart");
    expect_chg(7'b0111111, 0, k + 5 + L, "R10 count restarted after clock return");
    pulse_relock();
    wait_until(k);
    clk_settled = 1'b0;
    repeat (5) @(negedge clk);
    clk_settled = 1'b1;
    wait_until(k + 5 + L + 3);
    check(ready === 1'b1, "R10 ready after restart", {6'b0, ready}, 7'b1);
    check(dll_enable === 1'b1 && mclk_en === 1'b1 && rail_on === 3'b111,
          "R12 chain on with ready", outs, 7'b0111111);
    check(qv.size() == 0, "R5 all scheduled changes seen", 7'(qv.size()), 7'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R1..R12 run): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule